// File: doc/BRIEF.md
# Coprocessor Task Dispatch Controller

This block schedules work for a small coprocessor that runs beside a main CPU. It handles eight tasks. Each task can be triggered by a peripheral event, by a software force through the register interface, or by a direct acknowledge-style strobe from the CPU. The block records for every task whether it is pending, enabled, running, and whether a trigger was lost because the task was already pending.

Whenever the coprocessor is idle, the block picks one task from those that are both pending and enabled. It starts that task by presenting the task's 16-bit start address from a vector register file, together with a one-cycle start strobe. Tasks run to completion and are never nested. The coprocessor signals the end of a task with a strobe. The block then raises a one-cycle completion interrupt for that task. On the next cycle it automatically starts the best remaining candidate.

Top module: `task_dispatch_ctrl`

## Requirements
- R1: After synchronous reset, the pending, overflow, enable, run and source-select registers read 0, and `start_strobe` and `cpl_irq` are low.
- R2: The source-select register is at address 0x17, with bit i for task i+1. When the bit is 0, the task is triggered by `adc_evt[i]`. When it is 1, tasks 1 to 7 are triggered by `pwm_evt[i]` and task 8 by `timer0_evt`. The unselected source has no effect.
- R3: Writing ones to the force register (0x12) sets the matching pending bits. A high bit of `cpu_ack_trig` does the same in that cycle. Pending bits read at address 0x10, with bit i for task i+1.
- R4: A triggered task whose enable bit is clear stays pending and is not started. The enable register is read/write at address 0x15.
- R5: When no task is running and some task is pending and enabled, the lowest-numbered such task is started on the next clock edge. Task 1 (bit 0) has the highest priority. At that edge its pending bit clears, its run bit sets, and `start_strobe` pulses for one cycle with `start_addr` equal to its vector and `start_task` equal to its index.
- R6: While any run bit is set, no other task starts, whatever its priority.
- R7: On `end_strobe` the run bit clears and `cpl_irq` pulses for one cycle on that task's bit. The next eligible task starts one cycle later.
- R8: A trigger that arrives while the task's pending bit is already set sets the task's overflow bit (address 0x11). The pending bit stays set.
- R9: The clear register (0x13) and the overflow-clear register (0x14) are write-one-to-clear. A trigger in the same cycle as a clear wins.
- R10: The vectors for tasks 1 to 8 are read/write at addresses 0x00 to 0x07. The run register (0x16) is read-only, so writes to it are ignored. `reg_rdata` shows the register addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_evt | input | 8 | Converter event per task |
| pwm_evt | input | 7 | PWM event for tasks 1 to 7 |
| timer0_evt | input | 1 | Timer event, alternate source for task 8 |
| cpu_ack_trig | input | 8 | Direct CPU trigger per task |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| end_strobe | input | 1 | Coprocessor end-of-task strobe |
| start_strobe | output | 1 | One-cycle task start |
| start_addr | output | 16 | Start address of the started task |
| start_task | output | 3 | Index of the started task |
| cpl_irq | output | 8 | One-cycle completion interrupt per task |

## Verification
The hardest case to reach is a high-priority task that becomes pending while a lower-priority task is running. It must wait, and it must then win over an older low-priority candidate once the running task ends. The bench sets up several pending tasks with the enable register clear, so that none can start. It then enables them all at once to start the middle one. While that task runs, it forces task 1. It then checks that nothing starts until `end_strobe` arrives, and that task 1 starts ahead of task 8.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int ADR_PEND   = 'h10;
  localparam int ADR_OVF    = 'h11;
  localparam int ADR_FORCE  = 'h12;
  localparam int ADR_CLR    = 'h13;
  localparam int ADR_OVFCLR = 'h14;
  localparam int ADR_ENA    = 'h15;
  localparam int ADR_RUN    = 'h16;
  localparam int ADR_SRC    = 'h17;
endpackage

// File: rtl/tdc_src_select.sv
module tdc_src_select #(
  parameter int N = 8
) (
  input  logic [N-1:0] adc_evt,
  input  logic [N-2:0] pwm_evt,
  input  logic         timer_evt,
  input  logic [N-1:0] sel,
  output logic [N-1:0] evt
);
  for (genvar i = 0; i < N; i++) begin : g_src
    if (i < N - 1) begin : g_pwm
      assign evt[i] = sel[i] ? pwm_evt[i] : adc_evt[i];
    end else begin : g_tmr
      assign evt[i] = sel[i] ? timer_evt : adc_evt[i];
    end
  end
endmodule

// File: rtl/tdc_pending_bank.sv
module tdc_pending_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] disp_clr,
  input  logic [N-1:0] sw_clr,
  input  logic [N-1:0] ovf_clr,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] ovf_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      ovf_q  <= '0;
    end else begin
      // a new trigger overrides any clear in the same cycle
      pend_q <= trig | (pend_q & ~sw_clr & ~disp_clr);
      ovf_q  <= (trig & pend_q) | (ovf_q & ~ovf_clr);
    end
  end

  AST_OVF_ON_REPEAT: assert property (@(posedge clk) disable iff (rst)
    (|(trig & pend_q)) |=> ((ovf_q & $past(trig & pend_q)) == $past(trig & pend_q))); // R8
  AST_TRIG_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
    (|trig) |=> ((pend_q & $past(trig)) == $past(trig))); // R9
endmodule

// File: rtl/tdc_prio_pick.sv
module tdc_prio_pick #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        idx = IW'(i);
      end
    end
    any = |req;
  end

  always_comb begin
    if (any) begin
      AST_PICK_LOWEST: assert (((grant - 1'b1) & req) == '0 && (grant & req) == grant); // R5
    end
  end
endmodule

// File: rtl/task_dispatch_ctrl.sv
module task_dispatch_ctrl #(
  parameter int NUM_TASKS = 8,
  parameter int VEC_W     = 16,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  localparam int IW       = $clog2(NUM_TASKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_TASKS-1:0] adc_evt,
  input  logic [NUM_TASKS-2:0] pwm_evt,
  input  logic                 timer0_evt,
  input  logic [NUM_TASKS-1:0] cpu_ack_trig,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic                 end_strobe,
  output logic                 start_strobe,
  output logic [VEC_W-1:0]     start_addr,
  output logic [IW-1:0]        start_task,
  output logic [NUM_TASKS-1:0] cpl_irq
);
  import tdc_pkg::*;
  localparam int N = NUM_TASKS;

  logic [N-1:0]     en_q, src_q, run_q;
  logic [N-1:0]     pend_q, ovf_q, evt, trig;
  logic [N-1:0]     force_set, sw_clr, ovf_clr, disp_clr;
  logic [N-1:0]     grant;
  logic [IW-1:0]    pick_idx;
  logic             pick_any, dispatch;
  logic [VEC_W-1:0] vec_q [N];

  function automatic logic hit(input int a);
    return reg_we && (reg_addr == ADDR_W'(a));
  endfunction

  assign force_set = hit(ADR_FORCE)  ? reg_wdata[N-1:0] : '0;
  assign sw_clr    = hit(ADR_CLR)    ? reg_wdata[N-1:0] : '0;
  assign ovf_clr   = hit(ADR_OVFCLR) ? reg_wdata[N-1:0] : '0;

  tdc_src_select #(.N(N)) src_i (
    .adc_evt(adc_evt), .pwm_evt(pwm_evt), .timer_evt(timer0_evt),
    .sel(src_q), .evt(evt)
  );

  assign trig = evt | force_set | cpu_ack_trig;

  tdc_pending_bank #(.N(N)) pend_i (
    .clk(clk), .rst(rst), .trig(trig), .disp_clr(disp_clr),
    .sw_clr(sw_clr), .ovf_clr(ovf_clr), .pend_q(pend_q), .ovf_q(ovf_q)
  );

  tdc_prio_pick #(.N(N)) pick_i (
    .req(pend_q & en_q), .grant(grant), .idx(pick_idx), .any(pick_any)
  );

  assign dispatch = pick_any && (run_q == '0);
  assign disp_clr = dispatch ? grant : '0;

  // vector file: plain write port, no reset, so it can map to RAM
  always_ff @(posedge clk) begin
    if (reg_we && (reg_addr < ADDR_W'(N))) begin
      vec_q[reg_addr[IW-1:0]] <= reg_wdata[VEC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      src_q <= '0;
    end else begin
      if (hit(ADR_ENA)) en_q  <= reg_wdata[N-1:0];
      if (hit(ADR_SRC)) src_q <= reg_wdata[N-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q        <= '0;
      start_strobe <= 1'b0;
      start_addr   <= '0;
      start_task   <= '0;
      cpl_irq      <= '0;
    end else begin
      start_strobe <= 1'b0;
      cpl_irq      <= '0;
      if (end_strobe && (run_q != '0)) begin
        cpl_irq <= run_q;
        run_q   <= '0;
      end else if (dispatch) begin
        run_q        <= grant;
        start_strobe <= 1'b1;
        start_addr   <= vec_q[pick_idx];
        start_task   <= pick_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_addr < ADDR_W'(N)) begin
      reg_rdata <= DATA_W'(vec_q[reg_addr[IW-1:0]]);
    end else begin
      case (int'(reg_addr))
        ADR_PEND: reg_rdata <= DATA_W'(pend_q);
        ADR_OVF:  reg_rdata <= DATA_W'(ovf_q);
        ADR_ENA:  reg_rdata <= DATA_W'(en_q);
        ADR_RUN:  reg_rdata <= DATA_W'(run_q);
        ADR_SRC:  reg_rdata <= DATA_W'(src_q);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  AST_SINGLE_RUN: assert property (@(posedge clk) disable iff (rst)
    $onehot0(run_q)); // R6
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    start_strobe |-> ($past(run_q) == '0 && $onehot(run_q))); // R5
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (run_q != '0 && !end_strobe) |=> (run_q == $past(run_q) && !start_strobe)); // R6
  AST_CPL_PULSE: assert property (@(posedge clk) disable iff (rst)
    (cpl_irq != '0) |-> ($onehot(cpl_irq) && run_q == '0 && cpl_irq == $past(run_q))); // R7
endmodule

// File: tb/task_dispatch_ctrl_tb_top.sv
module task_dispatch_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  adc_evt = '0;
  logic [6:0]  pwm_evt = '0;
  logic        timer0_evt = 1'b0;
  logic [7:0]  cpu_ack_trig = '0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        end_strobe = 1'b0;
  logic        start_strobe;
  logic [15:0] start_addr;
  logic [2:0]  start_task;
  logic [7:0]  cpl_irq;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  task_dispatch_ctrl dut_i (
    .clk(clk), .rst(rst), .adc_evt(adc_evt), .pwm_evt(pwm_evt),
    .timer0_evt(timer0_evt), .cpu_ack_trig(cpu_ack_trig),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .end_strobe(end_strobe),
    .start_strobe(start_strobe), .start_addr(start_addr),
    .start_task(start_task), .cpl_irq(cpl_irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    reg_addr = a;
    tick();
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 strobe", {31'd0, start_strobe}, 0);
    chk("R1 cpl", {24'd0, cpl_irq}, 0);
    rd(5'h10, d); chk("R1 pend", {16'd0, d}, 0);
    rd(5'h11, d); chk("R1 ovf", {16'd0, d}, 0);
    rd(5'h15, d); chk("R1 ena", {16'd0, d}, 0);
    rd(5'h16, d); chk("R1 run", {16'd0, d}, 0);
    rd(5'h17, d); chk("R1 src", {16'd0, d}, 0);
  endtask

  task automatic t_vectors();
    logic [15:0] d;
    for (int i = 0; i < 8; i++) wr(5'(i), 16'h1000 + 16'(i) * 16'h0111);
    for (int i = 0; i < 8; i++) begin
      rd(5'(i), d);
      chk("R10 vector", {16'd0, d}, {16'd0, 16'h1000 + 16'(i) * 16'h0111});
    end
    wr(5'h16, 16'h00FF);
    rd(5'h16, d); chk("R10 run read-only", {16'd0, d}, 0);
  endtask

  task automatic t_source_select();
    logic [15:0] d;
    pwm_evt[1] = 1'b1; tick(); pwm_evt[1] = 1'b0;
    rd(5'h10, d); chk("R2 pwm ignored when sel=0", {16'd0, d}, 0);
    adc_evt[1] = 1'b1; tick(); adc_evt[1] = 1'b0;
    rd(5'h10, d); chk("R2 adc selected", {16'd0, d}, 16'h0002);
    wr(5'h13, 16'h00FF);
    wr(5'h17, 16'h0082);
    adc_evt[7] = 1'b1; adc_evt[1] = 1'b1; tick(); adc_evt = '0;
    rd(5'h10, d); chk("R2 adc ignored when sel=1", {16'd0, d}, 0);
    timer0_evt = 1'b1; pwm_evt[1] = 1'b1; tick(); timer0_evt = 1'b0; pwm_evt = '0;
    rd(5'h10, d); chk("R2 timer and pwm", {16'd0, d}, 16'h0082);
    wr(5'h13, 16'h00FF);
    wr(5'h17, 16'h0000);
  endtask

  task automatic t_sw_and_overflow();
    logic [15:0] d;
    wr(5'h12, 16'h0011);
    cpu_ack_trig = 8'h04; tick(); cpu_ack_trig = '0;
    rd(5'h10, d); chk("R3 force and ack", {16'd0, d}, 16'h0015);
    adc_evt[0] = 1'b1; tick(); adc_evt[0] = 1'b0;
    rd(5'h11, d); chk("R8 overflow set", {16'd0, d}, 16'h0001);
    rd(5'h10, d); chk("R8 pending stays", {16'd0, d}, 16'h0015);
    wr(5'h14, 16'h0001);
    rd(5'h11, d); chk("R9 overflow clear", {16'd0, d}, 0);
    wr(5'h13, 16'h0005);
    rd(5'h10, d); chk("R9 pending clear", {16'd0, d}, 16'h0010);
    adc_evt[3] = 1'b1; wr(5'h13, 16'h0018); adc_evt[3] = 1'b0;
    rd(5'h10, d); chk("R9 set beats clear", {16'd0, d}, 16'h0008);
    wr(5'h13, 16'h00FF);
  endtask

  task automatic t_dispatch();
    logic [15:0] d;
    wr(5'h12, 16'h00A0);
    tick();
    chk("R4 disabled not started", {31'd0, start_strobe}, 0);
    rd(5'h10, d); chk("R4 disabled stays pending", {16'd0, d}, 16'h00A0);
    wr(5'h15, 16'h00FF);
    tick();
    chk("R5 strobe", {31'd0, start_strobe}, 1);
    chk("R5 task", {29'd0, start_task}, 5);
    chk("R5 addr", {16'd0, start_addr}, {16'd0, 16'h1000 + 16'd5 * 16'h0111});
    wr(5'h12, 16'h0001);
    chk("R5 strobe one cycle", {31'd0, start_strobe}, 0);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R6 no nesting", {31'd0, start_strobe}, 0);
    end
    rd(5'h16, d); chk("R6 run bit", {16'd0, d}, 16'h0020);
    rd(5'h10, d); chk("R5 pending cleared", {16'd0, d}, 16'h0081);
    end_strobe = 1'b1; tick(); end_strobe = 1'b0;
    chk("R7 cpl", {24'd0, cpl_irq}, 32'h20);
    chk("R7 no start with cpl", {31'd0, start_strobe}, 0);
    tick();
    chk("R7 cpl one cycle", {24'd0, cpl_irq}, 0);
    chk("R7 auto start", {31'd0, start_strobe}, 1);
    chk("R5 priority task1", {29'd0, start_task}, 0);
    end_strobe = 1'b1; tick(); end_strobe = 1'b0;
    chk("R7 cpl task1", {24'd0, cpl_irq}, 32'h01);
    tick();
    chk("R7 task8 next", {29'd0, start_task}, 7);
    chk("R7 task8 strobe", {31'd0, start_strobe}, 1);
    end_strobe = 1'b1; tick(); end_strobe = 1'b0;
    chk("R7 cpl task8", {24'd0, cpl_irq}, 32'h80);
    tick();
    chk("R5 idle", {31'd0, start_strobe}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_vectors();
    t_source_select();
    t_sw_and_overflow();
    t_dispatch();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule